// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block counts through ten states held in a five-bit twisted-ring (Johnson) shift register and presents the current state as ten one-hot outputs plus a carry that is high for the first half of the cycle and low for the second half. The carry therefore divides the count rate by ten with a 50% duty cycle. It is the natural building block for sequencers, strobe generators and clock-ratio dividers that need a glitch-free, one-bit-per-step state.

Two asynchronous count inputs drive it. The step line advances the count on its rising edge while the active-low enable is low. The enable line can also serve as a count input: while the step line is high, a falling edge on the enable advances the count. Both lines pass through two-flop synchronisers into the system clock, and their edges are found there. An active-high reset acts at once, without waiting for a clock edge, and puts the counter back at its first state.

Top module: `johnson_decade_counter`

## Requirements
- R1: While `rst` is high, `dec_out` is 0000000001 (only bit 0 set) and `carry_out` is 1 immediately, before any clock edge and whatever the count inputs do.
- R2: With `step_en_n` low, each low-to-high transition of `step_in` advances the count by exactly one state.
- R3: With `step_in` high, a high-to-low transition of `step_en_n` advances the count by exactly one state.
- R4: While `step_en_n` is high, transitions of `step_in` leave the count unchanged.
- R5: While `step_in` is low, transitions of `step_en_n` leave the count unchanged.
- R6: `carry_out` is 1 while the active output is bit 0 to bit 4 of `dec_out` and 0 while it is bit 5 to bit 9.
- R7: Outside reset exactly one bit of `dec_out` is high, and the active bit moves from bit 0 upward to bit 9 and then back to bit 0.
- R8: A rising edge on `step_in` and a falling edge on `step_en_n` that land in the same system cycle advance the count by one state, not two.
- R9: A qualifying count-input transition applied between clock edges appears at the outputs on the third rising `clk` edge after it, and not before.
- R10: After a reset applied mid-sequence and released, the next qualifying count edge moves the active output from bit 0 to bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset to state 0 |
| step_in | input | 1 | Asynchronous count input, counts on its rising edge |
| step_en_n | input | 1 | Asynchronous active-low enable; its falling edge counts while `step_in` is high |
| dec_out | output | 10 | One-hot decoded count, bit k high in state k |
| carry_out | output | 1 | High in states 0 to 4, low in states 5 to 9 |

## Verification
A corrupted ring register shows at the ports on the very next clock edge, because the registered decode follows the ring state directly: either no output or two outputs go high, or the carry disagrees with which half of the sequence the active bit sits in. A fault in the edge qualification shows as a missing, doubled or spurious step, visible three clock edges after the offending input transition, as a one-hot output that is one position off from where the count of applied edges predicts. A broken reset path shows within the same cycle, before any edge, as a `dec_out` other than bit 0.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Synchronised view of one asynchronous input line.
  typedef struct packed {
    logic level;  // synchronised level
    logic rise;   // one-cycle pulse on a 0 -> 1 change
    logic fall;   // one-cycle pulse on a 1 -> 0 change
  } line_event_t;

endpackage

// File: rtl/jdc_edge_sync.sv
module jdc_edge_sync
  import jdc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        din,
  output line_event_t ev
);

  localparam int WARM_W = STAGES + 1;

  logic [STAGES-1:0] chain;
  logic              prev;
  logic [WARM_W-1:0] warm;
  logic              armed;

  // Data path carries no reset: it only ever holds samples of the pin.
  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], din};
    prev  <= chain[STAGES-1];
  end

  // Edges are trusted only once the chain and the previous sample are full.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) warm <= '0;
    else     warm <= {warm[WARM_W-2:0], 1'b1};
  end

  assign armed    = warm[WARM_W-1];
  assign ev.level = chain[STAGES-1];
  assign ev.rise  = armed &  chain[STAGES-1] & ~prev;
  assign ev.fall  = armed & ~chain[STAGES-1] &  prev;

  // R9: an edge pulse lasts one cycle, so one transition makes one step
  assert_single_rise_R9: assert property (@(posedge clk) disable iff (rst)
    ev.rise |=> !ev.rise);
  assert_single_fall_R9: assert property (@(posedge clk) disable iff (rst)
    ev.fall |=> !ev.fall);

endmodule

// File: rtl/jdc_step_qual.sv
module jdc_step_qual
  import jdc_pkg::*;
(
  input  line_event_t step_ev,
  input  line_event_t en_ev,
  output logic        adv
);

  logic via_step;
  logic via_enable;

  always_comb begin
    via_step   = step_ev.rise & ~en_ev.level;  // R2
    via_enable = en_ev.fall   &  step_ev.level; // R3
    adv        = via_step | via_enable;         // R8: merged into one step
  end

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int RING_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  output logic [RING_BITS-1:0] ring,
  output logic [RING_BITS-1:0] ring_next
);

  localparam int MSB = RING_BITS - 1;

  logic                 legal;
  logic [RING_BITS-1:0] shifted;

  // A legal twisted-ring pattern has at most one change between neighbours.
  always_comb begin
    int unsigned flips;
    flips = 0;
    for (int i = 0; i < MSB; i++) begin
      if (ring[i] != ring[i+1]) flips++;
    end
    legal = (flips <= 1);
  end

  always_comb begin
    shifted = {ring[MSB-1:0], ~ring[MSB]};
    if (!adv)       ring_next = ring;
    else if (legal) ring_next = shifted;
    else            ring_next = '0;  // recover to state 0 in one step
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) ring <= '0;
    else     ring <= ring_next;
  end

  // R4/R5: without a qualified step the ring holds
  assert_ring_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ring));

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int RING_BITS = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RING_BITS-1:0]   ring_next,
  output logic [2*RING_BITS-1:0] dec_q,
  output logic                   carry_q
);

  localparam int N     = RING_BITS;
  localparam int OUT_W = 2 * RING_BITS;

  logic [OUT_W-1:0] dec_d;

  // Each state is picked out by one pair of adjacent ring bits.
  for (genvar k = 0; k < N; k++) begin : g_pair
    if (k == 0) begin : g_ends
      assign dec_d[0] = ~ring_next[N-1] & ~ring_next[0];
      assign dec_d[N] =  ring_next[N-1] &  ring_next[0];
    end else begin : g_mid
      assign dec_d[k]   =  ring_next[k-1] & ~ring_next[k];
      assign dec_d[N+k] = ~ring_next[k-1] &  ring_next[k];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dec_q   <= OUT_W'(1);
      carry_q <= 1'b1;
    end else begin
      dec_q   <= dec_d;
      carry_q <= ~ring_next[N-1];
    end
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(dec_q) == 1);
  assert_carry_half_R6: assert property (@(posedge clk) disable iff (rst)
    carry_q == (|dec_q[N-1:0]));

endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter
  import jdc_pkg::*;
#(
  parameter int RING_BITS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_in,
  input  logic                   step_en_n,
  output logic [2*RING_BITS-1:0] dec_out,
  output logic                   carry_out
);

  localparam int OUT_W = 2 * RING_BITS;

  line_event_t          step_ev;
  line_event_t          en_ev;
  logic                 adv;
  logic [RING_BITS-1:0] ring;
  logic [RING_BITS-1:0] ring_next;

  jdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_step (
    .clk(clk), .rst(rst), .din(step_in), .ev(step_ev)
  );

  jdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
    .clk(clk), .rst(rst), .din(step_en_n), .ev(en_ev)
  );

  jdc_step_qual u_qual (
    .step_ev(step_ev), .en_ev(en_ev), .adv(adv)
  );

  jdc_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk(clk), .rst(rst), .adv(adv), .ring(ring), .ring_next(ring_next)
  );

  jdc_decode #(.RING_BITS(RING_BITS)) u_dec (
    .clk(clk), .rst(rst), .ring_next(ring_next),
    .dec_q(dec_out), .carry_q(carry_out)
  );

  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> dec_out == {$past(dec_out[OUT_W-2:0]), $past(dec_out[OUT_W-1])});
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(dec_out) && $stable(carry_out));
  assert_falling_step_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (step_ev.fall && !en_ev.fall) |-> !adv);
  assert_rising_enable_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (en_ev.rise && !step_ev.rise) |-> !adv);

endmodule

// File: tb/johnson_decade_counter_bench.sv
module johnson_decade_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int SETTLE     = 5;

  typedef struct {
    int    idx;
    string tag;
  } exp_item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_in = 1'b0;
  logic         step_en_n = 1'b0;
  logic [W-1:0] dec_out;
  logic         carry_out;

  int        n_checks = 0;
  int        n_fail   = 0;
  int        exp_idx  = 0;
  bit        done     = 1'b0;
  exp_item_t sb[$];

  johnson_decade_counter u_johnson_decade_counter (
    .clk(clk), .rst(rst), .step_in(step_in), .step_en_n(step_en_n),
    .dec_out(dec_out), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] q_of(int idx);
    return W'(1) << idx;
  endfunction

  task automatic check_state(string tag, int idx);
    n_checks++;
    if (dec_out !== q_of(idx) || carry_out !== (idx < 5)) begin
      n_fail++;
      $display("FAIL %s: dec_out=%b carry=%b expected dec_out=%b carry=%b",
               tag, dec_out, carry_out, q_of(idx), (idx < 5));
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(string tag);
    exp_item_t it;
    it.idx = exp_idx;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Driver: one step_in pulse with enable low; expects one step (R2).
  task automatic pulse_step(string tag);
    step_in = 1'b1;
    wait_cycles(SETTLE);
    exp_idx = (exp_idx + 1) % 10;
    push_exp(tag);
    step_in = 1'b0;
    wait_cycles(SETTLE);
  endtask

  // Monitor: scoreboard pops plus per-cycle invariants.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!rst) begin
        n_checks++;
        if ($countones(dec_out) != 1) begin
          n_fail++;
          $display("FAIL R7: dec_out=%b expected exactly one bit set", dec_out);
        end
        n_checks++;
        if (carry_out !== (|dec_out[4:0])) begin
          n_fail++;
          $display("FAIL R6: carry=%b expected %b for dec_out=%b",
                   carry_out, (|dec_out[4:0]), dec_out);
        end
      end
      if (sb.size() > 0) begin
        exp_item_t it;
        it = sb.pop_front();
        check_state(it.tag, it.idx);
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state while inputs move
    wait_cycles(2);
    step_in = 1'b1;
    wait_cycles(2);
    step_in = 1'b0;
    wait_cycles(2);
    check_state("R1 reset state", 0);
    rst = 1'b0;
    wait_cycles(SETTLE);
    exp_idx = 0;
    push_exp("R1 state after release");
    wait_cycles(2);

    // R9: exact latency of three rising edges
    step_in = 1'b1;
    wait_cycles(2);
    check_state("R9 unchanged after two edges", 0);
    wait_cycles(1);
    check_state("R9 stepped after three edges", 1);
    exp_idx = 1;
    step_in = 1'b0;
    wait_cycles(SETTLE);

    // R2/R6/R7: two full wraps and a bit more
    for (int i = 0; i < 21; i++) pulse_step("R2 R7 rising step");

    // R4: enable high blocks step_in (raise enable while step_in low)
    step_en_n = 1'b1;
    wait_cycles(SETTLE);
    for (int i = 0; i < 3; i++) begin
      step_in = 1'b1;
      wait_cycles(SETTLE);
      step_in = 1'b0;
      wait_cycles(SETTLE);
    end
    push_exp("R4 inhibited count holds");
    wait_cycles(2);

    // R3: falling enable counts while step_in is high
    step_in = 1'b1;
    wait_cycles(SETTLE);
    push_exp("R3 no step from step_in while inhibited");
    wait_cycles(1);
    step_en_n = 1'b0;
    wait_cycles(SETTLE);
    exp_idx = (exp_idx + 1) % 10;
    push_exp("R3 falling enable step");
    wait_cycles(1);
    step_in = 1'b0;
    wait_cycles(SETTLE);

    // R5: enable toggles while step_in low
    for (int i = 0; i < 3; i++) begin
      step_en_n = 1'b1;
      wait_cycles(SETTLE);
      step_en_n = 1'b0;
      wait_cycles(SETTLE);
    end
    push_exp("R5 enable toggles with step_in low");
    wait_cycles(2);

    // R8: both edges in the same cycle give one step
    step_en_n = 1'b1;
    wait_cycles(SETTLE);
    step_in   = 1'b1;
    step_en_n = 1'b0;
    wait_cycles(SETTLE);
    exp_idx = (exp_idx + 1) % 10;
    push_exp("R8 coincident edges single step");
    wait_cycles(1);
    step_in = 1'b0;
    wait_cycles(SETTLE);

    // R10 / R1: asynchronous reset in mid-sequence
    for (int i = 0; i < 3; i++) pulse_step("R2 before reset");
    wait_cycles(2);
    #(CLK_PERIOD/4);
    rst = 1'b1;
    #1;
    check_state("R1 async reset before edge", 0);
    exp_idx = 0;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(SETTLE);
    push_exp("R10 state 0 after release");
    wait_cycles(2);
    pulse_step("R10 first step after reset");
    pulse_step("R10 second step after reset");

    wait_cycles(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule